// File: doc/BRIEF.md
# Ring-Table Frequency Modulator

This block bends the pitch of a wavetable oscillator. It holds a ring of 3-bit step codes. A phase accumulator reads the ring at a programmable rate. Each code it reads nudges a 7-bit signed bias up or down, or clears it to zero. From the bias, an external modulation gain and the oscillator's 12-bit carrier frequency, the block forms a signed frequency offset every clock. The oscillator adds that offset to its own frequency.

Software controls the block through four write strobes that share one data byte:

- a low and a high byte of the modulation rate, where the high byte also carries a disable flag;
- a table-fill byte;
- a direct bias load.

The ring can be refilled only while the disable flag is set. Each fill byte covers two neighbouring ring slots. The gain comes from an envelope outside this block.

Top module: `ringfm_mod`

## Requirements
- R1: After reset the offset is 0, the bias is 0, every ring slot holds code 0, the ring position is 0, the rate is 0 and the disable flag is set.
- R2: A strobe on `rate_lo_we` loads `wr_data[7:0]` into rate bits 7..0. A strobe on `rate_hi_we` loads `wr_data[3:0]` into rate bits 11..8 and `wr_data[7]` into the disable flag. While the unit is active, a 16-bit timer adds the rate every clock and raises a step on its carry out. With rate 0x800 and a cleared timer, the first step falls on the 32nd clock after the enabling write, and later steps follow every 32 clocks.
- R3: On each step, the code at the current ring position changes the bias: code 0 adds 0, 1 adds 1, 2 adds 2, 3 adds 4, 5 adds -4, 6 adds -2 and 7 adds -1. The position then moves forward by one.
- R4: A step on code 4 sets the bias to 0.
- R5: Bias arithmetic wraps in 7-bit two's complement: 62 plus 4 gives -62, and -63 minus 4 gives 61.
- R6: A fill strobe (`table_we`, code in `wr_data[2:0]`) while the disable flag is set writes the code into the slot at the current position and the slot after it, then moves the position forward by two. After 32 fills the position is back where it started.
- R7: An accepted fill clears the step timer, so after the unit is re-enabled the first step comes a full 32 clocks later at rate 0x800.
- R8: A fill strobe while the disable flag is clear changes no slot, no position and no timer state.
- R9: While the disable flag is set or the rate is 0, the unit is inactive. No steps occur, the bias holds, and the offset is 0 from the next clock on.
- R10: A strobe on `bias_we` loads `wr_data[6:0]` as a two's-complement bias from -64 to 63. It takes priority over a step in the same clock.
- R11: While active, the offset follows one clock after its inputs and is computed in this order:
  - p = bias × gain;
  - q = p / 16, truncating toward zero;
  - if p[3:0] is not zero, q is then decreased by 1 for a negative bias or increased by 2 otherwise;
  - if q > 193, subtract 258; then, if q < -64, add 256;
  - offset = carrier × q / 64, truncating toward zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_data | input | 8 | Data byte shared by all write strobes |
| rate_lo_we | input | 1 | Load rate bits 7..0 |
| rate_hi_we | input | 1 | Load rate bits 11..8 and the disable flag |
| table_we | input | 1 | Fill two ring slots with a 3-bit code |
| bias_we | input | 1 | Load the bias directly |
| gain_i | input | 6 | Modulation gain, unsigned |
| carrier_i | input | 12 | Carrier frequency of the oscillator, unsigned |
| offset_o | output | 16 | Signed frequency offset |

## Verification
A ring filled with a period-8 code pattern drives the bias through every code's effect, and each step is sampled in the middle of its 32-clock window. This separates a wrong code map, a wrong step rate and a wrong first-step delay. Runs with all-+4 and all--4 rings, started near each end of the range, expose a bias that saturates instead of wrapping. A ring holding a single nonzero pair that is reached only after 62 steps shows whether fills start at the current position and whether 32 fills come back around. A fixed-bias sweep of gain and carrier pairs covers the following cases, each of which a simpler divide or wrap would get wrong:
- the zero and nonzero low-bit rounding paths for both signs;
- both wrap thresholds, including the just-over-193 case;
- truncation toward zero in the final scale.

// File: rtl/ringfm_pkg.sv
package ringfm_pkg;

   localparam int BIAS_W = 7;
   localparam int CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      C_HOLD = 3'd0,
      C_UP1  = 3'd1,
      C_UP2  = 3'd2,
      C_UP4  = 3'd3,
      C_ZERO = 3'd4,
      C_DN4  = 3'd5,
      C_DN2  = 3'd6,
      C_DN1  = 3'd7
   } step_code_e;

   // Apply one ring code to the bias; the sum wraps in BIAS_W bits.
   function automatic logic signed [BIAS_W-1:0] next_bias(
      input logic signed [BIAS_W-1:0] cur,
      input logic [CODE_W-1:0]        code
   );
      logic signed [BIAS_W:0] delta;
      logic signed [BIAS_W:0] wide;
      delta = '0;
      case (step_code_e'(code))
         C_HOLD:  delta = '0;
         C_UP1:   delta = (BIAS_W+1)'(1);
         C_UP2:   delta = (BIAS_W+1)'(2);
         C_UP4:   delta = (BIAS_W+1)'(4);
         C_DN4:   delta = (BIAS_W+1)'(-4);
         C_DN2:   delta = (BIAS_W+1)'(-2);
         C_DN1:   delta = (BIAS_W+1)'(-1);
         default: delta = '0;
      endcase
      wide = {cur[BIAS_W-1], cur} + delta;
      if (step_code_e'(code) == C_ZERO)
         next_bias = '0;
      else
         next_bias = wide[BIAS_W-1:0];
   endfunction

endpackage

// File: rtl/ringfm_rate.sv
module ringfm_rate #(
   parameter int FREQ_W = 12,
   parameter int ACC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              clear_i,
   input  logic [FREQ_W-1:0] step_i,
   output logic              tick_o,
   output logic [ACC_W-1:0]  phase_o
);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W:0]   sum;

   always_comb begin
      sum    = {1'b0, acc_q} + (ACC_W+1)'(step_i);
      tick_o = run_i & sum[ACC_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       acc_q <= '0;
      else if (clear_i) acc_q <= '0;
      else if (run_i)   acc_q <= sum[ACC_W-1:0];
   end

   assign phase_o = acc_q;

endmodule

// File: rtl/ringfm_ring.sv
module ringfm_ring
   import ringfm_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int POS_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_i,
   input  logic [CODE_W-1:0] fill_code_i,
   input  logic              tick_i,
   output logic [CODE_W-1:0] code_o,
   output logic [POS_W-1:0]  pos_o
);

   logic [CODE_W-1:0] slot_q [DEPTH];
   logic [POS_W-1:0]  pos_q;
   logic [POS_W-1:0]  pos_nx1;

   assign pos_nx1 = pos_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      end else if (fill_i) begin
         slot_q[pos_q]   <= fill_code_i;
         slot_q[pos_nx1] <= fill_code_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      pos_q <= '0;
      else if (fill_i) pos_q <= pos_q + POS_W'(2);
      else if (tick_i) pos_q <= pos_nx1;
   end

   assign code_o = slot_q[pos_q];
   assign pos_o  = pos_q;

endmodule

// File: rtl/ringfm_bias.sv
module ringfm_bias
   import ringfm_pkg::*;
(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_i,
   input  logic signed [BIAS_W-1:0] load_val_i,
   input  logic                     tick_i,
   input  logic [CODE_W-1:0]        code_i,
   output logic signed [BIAS_W-1:0] bias_o
);

   logic signed [BIAS_W-1:0] bias_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      bias_q <= '0;
      else if (load_i) bias_q <= load_val_i;
      else if (tick_i) bias_q <= next_bias(bias_q, code_i);
   end

   assign bias_o = bias_q;

endmodule

// File: rtl/ringfm_offset.sv
module ringfm_offset
   import ringfm_pkg::*;
#(
   parameter int GAIN_W = 6,
   parameter int FREQ_W = 12,
   parameter int OFS_W  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     active_i,
   input  logic signed [BIAS_W-1:0] bias_i,
   input  logic [GAIN_W-1:0]        gain_i,
   input  logic [FREQ_W-1:0]        carrier_i,
   output logic signed [OFS_W-1:0]  offset_o
);

   localparam int PROD_W = BIAS_W + GAIN_W + 1;
   localparam int MUL_W  = PROD_W + FREQ_W + 1;

   localparam logic signed [PROD_W-1:0] FINE_DIV = PROD_W'(16);
   localparam logic signed [PROD_W-1:0] ADJ_NEG  = PROD_W'(-1);
   localparam logic signed [PROD_W-1:0] ADJ_POS  = PROD_W'(2);
   localparam logic signed [PROD_W-1:0] LIM_HI   = PROD_W'(193);
   localparam logic signed [PROD_W-1:0] FOLD_HI  = PROD_W'(258);
   localparam logic signed [PROD_W-1:0] LIM_LO   = PROD_W'(-64);
   localparam logic signed [PROD_W-1:0] FOLD_LO  = PROD_W'(256);
   localparam logic signed [MUL_W-1:0]  COARSE_DIV = MUL_W'(64);

   logic signed [PROD_W-1:0] b_ext, g_ext, prod, quo, folded;
   logic signed [MUL_W-1:0]  t_ext, c_ext, scaled;
   logic signed [OFS_W-1:0]  offset_q;

   always_comb begin
      b_ext = PROD_W'(bias_i);
      g_ext = $signed(PROD_W'(gain_i));
      prod  = b_ext * g_ext;
      quo   = prod / FINE_DIV;
      if (prod[3:0] != 4'd0)
         quo = quo + (bias_i[BIAS_W-1] ? ADJ_NEG : ADJ_POS);
      folded = quo;
      if (folded > LIM_HI) folded = folded - FOLD_HI;
      if (folded < LIM_LO) folded = folded + FOLD_LO;
      t_ext  = MUL_W'(folded);
      c_ext  = $signed(MUL_W'(carrier_i));
      scaled = (t_ext * c_ext) / COARSE_DIV;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        offset_q <= '0;
      else if (active_i) offset_q <= OFS_W'(scaled);
      else               offset_q <= '0;
   end

   assign offset_o = offset_q;

endmodule

// File: rtl/ringfm_mod.sv
module ringfm_mod
   import ringfm_pkg::*;
#(
   parameter int FREQ_W = 12,
   parameter int ACC_W  = 16,
   parameter int DEPTH  = 64,
   parameter int GAIN_W = 6,
   parameter int OFS_W  = FREQ_W + 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [7:0]              wr_data,
   input  logic                    rate_lo_we,
   input  logic                    rate_hi_we,
   input  logic                    table_we,
   input  logic                    bias_we,
   input  logic [GAIN_W-1:0]       gain_i,
   input  logic [FREQ_W-1:0]       carrier_i,
   output logic signed [OFS_W-1:0] offset_o
);

   localparam int HI_W  = FREQ_W - 8;
   localparam int POS_W = $clog2(DEPTH);

   generate
      if (FREQ_W < 9 || FREQ_W > 15) begin : g_bad_freq_w
         initial $fatal(1, "ringfm_mod: FREQ_W must lie in 9..15");
      end
      if (ACC_W <= FREQ_W) begin : g_bad_acc_w
         initial $fatal(1, "ringfm_mod: ACC_W must exceed FREQ_W");
      end
      if (DEPTH < 4 || (1 << POS_W) != DEPTH) begin : g_bad_depth
         initial $fatal(1, "ringfm_mod: DEPTH must be a power of two >= 4");
      end
      if (OFS_W < FREQ_W + 4) begin : g_bad_ofs_w
         initial $fatal(1, "ringfm_mod: OFS_W too narrow for the offset range");
      end
   endgenerate

   logic [FREQ_W-1:0]        rate_q;
   logic                     dis_q;
   logic                     active;
   logic                     fill_go;
   logic                     tick;
   logic [CODE_W-1:0]        cur_code;
   logic [POS_W-1:0]         ring_pos;
   logic [ACC_W-1:0]         timer_q;
   logic signed [BIAS_W-1:0] bias_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q <= '0;
         dis_q  <= 1'b1;
      end else begin
         if (rate_lo_we) rate_q[7:0] <= wr_data;
         if (rate_hi_we) begin
            rate_q[FREQ_W-1:8] <= wr_data[HI_W-1:0];
            dis_q              <= wr_data[7];
         end
      end
   end

   assign active  = !dis_q && (rate_q != '0);
   assign fill_go = table_we && dis_q;

   ringfm_rate #(.FREQ_W(FREQ_W), .ACC_W(ACC_W)) u_rate (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (active),
      .clear_i (fill_go),
      .step_i  (rate_q),
      .tick_o  (tick),
      .phase_o (timer_q)
   );

   ringfm_ring #(.DEPTH(DEPTH)) u_ring (
      .clk         (clk),
      .rst_n       (rst_n),
      .fill_i      (fill_go),
      .fill_code_i (wr_data[CODE_W-1:0]),
      .tick_i      (tick),
      .code_o      (cur_code),
      .pos_o       (ring_pos)
   );

   ringfm_bias u_bias (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (bias_we),
      .load_val_i ($signed(wr_data[BIAS_W-1:0])),
      .tick_i     (tick),
      .code_i     (cur_code),
      .bias_o     (bias_q)
   );

   ringfm_offset #(.GAIN_W(GAIN_W), .FREQ_W(FREQ_W), .OFS_W(OFS_W)) u_ofs (
      .clk       (clk),
      .rst_n     (rst_n),
      .active_i  (active),
      .bias_i    (bias_q),
      .gain_i    (gain_i),
      .carrier_i (carrier_i),
      .offset_o  (offset_o)
   );

endmodule

// File: rtl/ringfm_mod_chk.sv
module ringfm_mod_chk
   import ringfm_pkg::*;
#(
   parameter int POS_W = 6,
   parameter int ACC_W = 16,
   parameter int OFS_W = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     active,
   input logic                     dis,
   input logic                     table_we,
   input logic                     bias_we,
   input logic                     tick,
   input logic [CODE_W-1:0]        code,
   input logic [POS_W-1:0]         pos,
   input logic [ACC_W-1:0]         timer,
   input logic signed [BIAS_W-1:0] bias,
   input logic signed [OFS_W-1:0]  offset
);

   a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> offset == '0);

   a_r9_bias_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !bias_we) |=> $stable(bias));

   a_r3_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> pos == POS_W'($past(pos) + 1'b1));

   a_r6_fill_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (table_we && dis) |=> pos == POS_W'($past(pos) + 2'd2));

   a_r7_timer_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (table_we && dis) |=> timer == '0);

   a_r8_fill_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (table_we && !dis && !tick) |=> $stable(pos));

   a_r4_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && code == C_ZERO && !bias_we) |=> bias == '0);

endmodule

bind ringfm_mod ringfm_mod_chk #(.POS_W(POS_W), .ACC_W(ACC_W), .OFS_W(OFS_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .active   (active),
   .dis      (dis_q),
   .table_we (table_we),
   .bias_we  (bias_we),
   .tick     (tick),
   .code     (cur_code),
   .pos      (ring_pos),
   .timer    (timer_q),
   .bias     (bias_q),
   .offset   (offset_o)
);

// File: tb/ringfm_mod_tb_top.sv
`timescale 1ns/1ps
module ringfm_mod_tb_top;

   localparam int SEL_LO   = 0;
   localparam int SEL_HI   = 1;
   localparam int SEL_TBL  = 2;
   localparam int SEL_BIAS = 3;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [7:0]         wr_data = '0;
   logic               rate_lo_we = 1'b0;
   logic               rate_hi_we = 1'b0;
   logic               table_we = 1'b0;
   logic               bias_we = 1'b0;
   logic [5:0]         gain = '0;
   logic [11:0]        carrier = '0;
   logic signed [15:0] offset;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;
   int pat [32];

   ringfm_mod dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_data    (wr_data),
      .rate_lo_we (rate_lo_we),
      .rate_hi_we (rate_hi_we),
      .table_we   (table_we),
      .bias_we    (bias_we),
      .gain_i     (gain),
      .carrier_i  (carrier),
      .offset_o   (offset)
   );

   always #2 clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      rate_lo_we = 1'b0; rate_hi_we = 1'b0; table_we = 1'b0; bias_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input int sel, input logic [7:0] d);
      @(negedge clk);
      wr_data = d;
      case (sel)
         SEL_LO:  rate_lo_we = 1'b1;
         SEL_HI:  rate_hi_we = 1'b1;
         SEL_TBL: table_we   = 1'b1;
         default: bias_we    = 1'b1;
      endcase
      @(negedge clk);
      rate_lo_we = 1'b0; rate_hi_we = 1'b0; table_we = 1'b0; bias_we = 1'b0;
   endtask

   function automatic int step(input int b, input int c);
      int r;
      case (c)
         1: r = b + 1;
         2: r = b + 2;
         3: r = b + 4;
         4: r = 0;
         5: r = b - 4;
         6: r = b - 2;
         7: r = b - 1;
         default: r = b;
      endcase
      if (r > 63)  r = r - 128;
      if (r < -64) r = r + 128;
      return r;
   endfunction

   task automatic fill_ring();
      for (int k = 0; k < 32; k++) wr(SEL_TBL, 8'(pat[k]));
   endtask

   task automatic set_pat_const(input int c);
      for (int k = 0; k < 32; k++) pat[k] = c;
   endtask

   // R1: reset state
   task automatic t_reset();
      apply_reset();
      gain = 6'd16; carrier = 12'd64;
      @(negedge clk);
      chk("R1 offset after reset", int'(offset), 0);
      wr(SEL_HI, 8'h08);
      repeat (47) @(negedge clk);
      chk("R1 zero bias and zero ring after reset", int'(offset), 0);
   endtask

   // R2, R3, R4, R8, R9: pattern walk, ignored fill, inactive behaviour
   task automatic t_sequence();
      int base [8] = '{1, 2, 3, 5, 6, 7, 4, 0};
      int b;
      int c;
      for (int k = 0; k < 32; k++) pat[k] = base[k % 8];
      apply_reset();
      gain = 6'd16; carrier = 12'd64;
      wr(SEL_HI, 8'h80);
      wr(SEL_LO, 8'h00);
      fill_ring();
      wr(SEL_BIAS, 8'd10);
      b = 10;
      wr(SEL_HI, 8'h08);
      repeat (32) @(negedge clk);
      chk("R2 no step before 32 clocks", int'(offset), 10);
      repeat (15) @(negedge clk);
      for (int k = 0; k < 16; k++) begin
         if (k > 0) repeat (32) @(negedge clk);
         c = pat[k / 2];
         b = step(b, c);
         chk(c == 4 ? "R4 zero code clears bias" : "R3 step code adds to bias",
             int'(offset), b);
      end
      wr(SEL_TBL, 8'd7);
      repeat (30) @(negedge clk);
      for (int k = 16; k < 20; k++) begin
         if (k > 16) repeat (32) @(negedge clk);
         b = step(b, pat[k / 2]);
         chk("R8 fill while enabled is ignored", int'(offset), b);
      end
      wr(SEL_HI, 8'h88);
      @(negedge clk);
      chk("R9 offset zero when disabled", int'(offset), 0);
      repeat (100) @(negedge clk);
      wr(SEL_TBL, 8'd0);
      wr(SEL_HI, 8'h08);
      @(negedge clk);
      chk("R9 bias held while disabled", int'(offset), b);
      wr(SEL_HI, 8'h00);
      repeat (2) @(negedge clk);
      chk("R9 offset zero when rate is 0", int'(offset), 0);
   endtask

   // R5: wrap in both directions
   task automatic t_wrap();
      apply_reset();
      gain = 6'd16; carrier = 12'd64;
      set_pat_const(3);
      wr(SEL_HI, 8'h80);
      wr(SEL_LO, 8'h00);
      fill_ring();
      wr(SEL_BIAS, 8'h3E);
      wr(SEL_HI, 8'h08);
      repeat (47) @(negedge clk);
      chk("R5 62+4 wraps to -62", int'(offset), -62);
      repeat (32) @(negedge clk);
      chk("R5 -62+4", int'(offset), -58);
      wr(SEL_HI, 8'h88);
      set_pat_const(5);
      fill_ring();
      wr(SEL_BIAS, 8'h41);
      wr(SEL_HI, 8'h08);
      repeat (47) @(negedge clk);
      chk("R5 -63-4 wraps to 61", int'(offset), 61);
      repeat (32) @(negedge clk);
      chk("R5 61-4", int'(offset), 57);
   endtask

   // R6: fills land at current position in pairs, 32 fills come back around
   task automatic t_ring_wrap();
      apply_reset();
      gain = 6'd16; carrier = 12'd64;
      set_pat_const(0);
      wr(SEL_HI, 8'h80);
      wr(SEL_LO, 8'h00);
      fill_ring();
      wr(SEL_TBL, 8'd1);
      wr(SEL_HI, 8'h08);
      repeat (47 + 32 * 61) @(negedge clk);
      chk("R6 slots 2..63 still code 0", int'(offset), 0);
      repeat (32) @(negedge clk);
      chk("R6 33rd fill landed in slot 0", int'(offset), 1);
      repeat (32) @(negedge clk);
      chk("R6 33rd fill landed in slot 1", int'(offset), 2);
   endtask

   // R7: accepted fill restarts the step timer
   task automatic t_timer();
      apply_reset();
      gain = 6'd16; carrier = 12'd64;
      set_pat_const(1);
      wr(SEL_HI, 8'h80);
      wr(SEL_LO, 8'h00);
      fill_ring();
      wr(SEL_HI, 8'h08);
      repeat (16) @(negedge clk);
      wr(SEL_HI, 8'h88);
      wr(SEL_TBL, 8'd1);
      wr(SEL_HI, 8'h08);
      repeat (20) @(negedge clk);
      chk("R7 no early step after fill", int'(offset), 0);
      repeat (27) @(negedge clk);
      chk("R7 first step after full period", int'(offset), 1);
   endtask

   // R10, R11: direct bias loads and the offset formula
   task automatic t_formula();
      int cb [12] = '{5, -5, 63, -64, -64, 63, 63, -1, 7, 33, -64, 63};
      int cg [12] = '{3, 3, 63, 63, 1, 50, 49, 1, 0, 63, 16, 16};
      int cc [12] = '{640, 640, 4095, 100, 4095, 4095, 64, 64, 4095, 4095, 64, 64};
      int ce [12] = '{20, -10, -511, 6, -255, -3839, -64, -1, 0, 8381, -64, 63};
      apply_reset();
      wr(SEL_HI, 8'h80);
      wr(SEL_LO, 8'h00);
      wr(SEL_HI, 8'h08);
      for (int k = 0; k < 12; k++) begin
         wr(SEL_BIAS, 8'(cb[k]) & 8'h7F);
         gain = 6'(cg[k]);
         carrier = 12'(cc[k]);
         repeat (3) @(negedge clk);
         chk(k >= 10 ? "R10 bias load at range end" : "R11 offset formula",
             int'(offset), ce[k]);
      end
   endtask

   initial begin
      t_reset();
      t_sequence();
      t_wrap();
      t_ring_wrap();
      t_timer();
      t_formula();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule